// File: doc/BRIEF.md
# Dual-Bank Parallel Register Bus Front End

This block is the host-facing side of a sound generator that carries two identical banks of control registers. A host reaches it over a classic asynchronous parallel bus: a 6-bit address, an active-low chip select, a read/write line and an 8-bit bidirectional data bus. The upper address bit picks the bank. The lower five bits pick one of 32 byte registers inside that bank. Writes land in the chosen bank. Reads return the stored byte of any register, including registers that a voice engine would normally treat as write-only.

The whole register image of both banks is presented on a flat output. The synthesis logic downstream reads its settings from there. The bus front end has two ways of deciding when a write happens.
- In the default fast mode, the bus lines are sampled on every cycle of the fast core clock.
- When the sync-enable pin is pulled low, a write is taken only on a rising edge of a slower external bus clock. That edge is carried into the core clock domain through a two-flop synchronizer and an edge detector. This helps hosts whose strobes have poor timing relative to the core clock.

The bus is a plain strobe interface with no back-pressure. The register image is a level output with no handshake, so no valid/ready rules apply.

Top module: `sndbus_top`

## Requirements
- R1: While `rst_n` is low, and after it is released with no access, every register of both banks reads 0 and `regs_flat` is all zeros.
- R2: With `ext_sync_n` high, a write is committed on the first core clock edge at which `bus_cs_n` is low and `bus_rw` is low. The byte on `bus_data` is stored at that edge. If the same access is held over later edges, nothing further is stored, even if the address or data changes.
- R3: `bus_addr[5]` selects the bank: 0 for bank 0 and 1 for bank 1. `bus_addr[4:0]` selects the register. A write to one bank leaves every register of the other bank unchanged.
- R4: While `bus_cs_n` is high, no register changes and the block does not drive `bus_data`.
- R5: While `bus_cs_n` is low and `bus_rw` is high, `bus_data` carries the stored byte of the addressed register in the same cycle, without waiting for a clock edge. This holds for every address of both banks. The byte returned is the last value written there.
- R6: While `bus_cs_n` is low and `bus_rw` is low, the block does not drive `bus_data`.
- R7: With `ext_sync_n` low, a write is committed only on the third core clock edge after `ext_clk` rises, counting from the first edge that samples it high. At that edge `bus_cs_n` and `bus_rw` must both be low. Without an `ext_clk` rising edge, a held write access stores nothing.
- R8: With `ext_sync_n` low, each rising edge of `ext_clk` during a held write access commits the byte present at that time. Two edges within one access therefore leave the later byte stored.
- R9: `regs_flat[(b*32 + r)*8 +: 8]` always equals the stored byte of register `r` in bank `b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low reset, clears both banks |
| bus_addr | input | 6 | Bit 5 bank select, bits 4:0 register index |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rw | input | 1 | High = read, low = write |
| bus_data | inout | 8 | Bidirectional data bus |
| ext_clk | input | 1 | Slow external bus clock (held high when unused) |
| ext_sync_n | input | 1 | Low = qualify writes with `ext_clk` edges; high = core-clock sampling |
| regs_flat | output | 512 | Register image of both banks for downstream logic |

## Verification
The assertions check, on every cycle, several properties of the write path.
- No two write commits fall on back-to-back cycles.
- A commit happens only while select and write are low.
- In sync mode, a commit is always preceded by `ext_clk` having been high two edges earlier.
- A bank keeps its contents whenever it is not being written.
- Bank 0 stays unchanged across a bank-1 write.

Only the bench's scenarios can show the rest:
- A held access stores its first byte and not a later one.
- The exact edge at which a synchronized write lands.
- The read mux returns the right byte for each address.
- The block stays off the bus when it must.

// File: rtl/sndbus_pkg.sv
package sndbus_pkg;
  localparam int REG_AW_DEF  = 5;
  localparam int DATA_W_DEF  = 8;
  localparam int BANK_W_DEF  = 1;
  localparam int SYNC_ST_DEF = 2;

  typedef enum logic {
    MODE_SYNC = 1'b0,
    MODE_FAST = 1'b1
  } strobe_mode_e;
endpackage

// File: rtl/sndbus_strobe.sv
module sndbus_strobe
  import sndbus_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_ST_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rw,
  input  logic ext_clk,
  input  logic ext_sync_n,
  output logic wr_commit
);
  strobe_mode_e mode;
  logic wr_req;
  logic wr_req_q;
  logic [SYNC_STAGES:0] ext_sh;
  logic ext_edge;
  logic fast_commit;

  assign mode   = strobe_mode_e'(ext_sync_n);
  assign wr_req = !cs_n && !rw;

  // Fast mode: remember the previous request level so one access commits once
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_req_q <= 1'b0;
    else        wr_req_q <= wr_req;
  end
  assign fast_commit = wr_req && !wr_req_q;

  // Sync mode: synchronizer chain plus one more flop for edge detection,
  // reset high so the idle-high external clock yields no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sh <= '1;
    else        ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_clk};
  end
  assign ext_edge = ext_sh[SYNC_STAGES-1] && !ext_sh[SYNC_STAGES];

  always_comb begin
    unique case (mode)
      MODE_FAST: wr_commit = fast_commit;
      MODE_SYNC: wr_commit = ext_edge && wr_req;
      default:   wr_commit = 1'b0;
    endcase
  end

  // R2 / R8: a commit never repeats on the very next cycle
  a_r2_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit);

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      // R7: a synchronized commit follows ext_clk having been high two edges back
      a_r7_sync_edge_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_commit && !ext_sync_n) |-> $past(ext_clk, 2));
    end
  endgenerate
endmodule

// File: rtl/sndbus_bank.sv
module sndbus_bank
  import sndbus_pkg::*;
#(
  parameter int REG_AW = REG_AW_DEF,
  parameter int DATA_W = DATA_W_DEF
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                we,
  input  logic [REG_AW-1:0]                   waddr,
  input  logic [DATA_W-1:0]                   wdata,
  input  logic [REG_AW-1:0]                   raddr,
  output logic [DATA_W-1:0]                   rdata,
  output logic [(1<<REG_AW)*DATA_W-1:0]       image
);
  localparam int NREGS = 1 << REG_AW;

  logic [NREGS-1:0][DATA_W-1:0] store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) store <= '0;
    else if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
  assign image = store;

  // R4 / R3: contents hold whenever this bank is not written
  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(image));
endmodule

// File: rtl/sndbus_top.sv
module sndbus_top
  import sndbus_pkg::*;
#(
  parameter int REG_AW      = REG_AW_DEF,
  parameter int DATA_W      = DATA_W_DEF,
  parameter int BANK_W      = BANK_W_DEF,
  parameter int SYNC_STAGES = SYNC_ST_DEF
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic [REG_AW+BANK_W-1:0]                         bus_addr,
  input  logic                                             bus_cs_n,
  input  logic                                             bus_rw,
  inout  wire  [DATA_W-1:0]                                bus_data,
  input  logic                                             ext_clk,
  input  logic                                             ext_sync_n,
  output logic [(1<<BANK_W)*(1<<REG_AW)*DATA_W-1:0]        regs_flat
);
  localparam int NBANKS = 1 << BANK_W;
  localparam int NREGS  = 1 << REG_AW;
  localparam int IMG_W  = NREGS * DATA_W;

  logic                                wr_commit;
  logic [BANK_W-1:0]                   bank_sel;
  logic [REG_AW-1:0]                   reg_idx;
  logic [NBANKS-1:0]                   bank_we;
  logic [NBANKS-1:0][DATA_W-1:0]       bank_rd;
  logic [NBANKS-1:0][IMG_W-1:0]        bank_img;
  logic                                rd_oe;
  logic [DATA_W-1:0]                   rd_byte;

  assign bank_sel = bus_addr[REG_AW+BANK_W-1:REG_AW];
  assign reg_idx  = bus_addr[REG_AW-1:0];

  sndbus_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (bus_cs_n),
    .rw         (bus_rw),
    .ext_clk    (ext_clk),
    .ext_sync_n (ext_sync_n),
    .wr_commit  (wr_commit)
  );

  generate
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      assign bank_we[b] = wr_commit && (bank_sel == BANK_W'(b));
      sndbus_bank #(.REG_AW(REG_AW), .DATA_W(DATA_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we[b]),
        .waddr (reg_idx),
        .wdata (bus_data),
        .raddr (reg_idx),
        .rdata (bank_rd[b]),
        .image (bank_img[b])
      );
    end
  endgenerate

  assign rd_byte   = bank_rd[bank_sel];
  assign rd_oe     = !bus_cs_n && bus_rw;
  assign bus_data  = rd_oe ? rd_byte : 'z;
  assign regs_flat = bank_img;

  // R2 / R4 / R6: a commit only occurs inside an enabled write access
  a_r2_commit_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (!bus_cs_n && !bus_rw));

  // R3: writing bank 1 leaves bank 0 untouched
  a_r3_bank_isolation: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && bank_sel != '0) |=> $stable(bank_img[0]));

  // R3: at most one bank write enable at a time
  a_r3_one_bank_we: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));
endmodule

// File: tb/sndbus_top_tb.sv
module sndbus_top_tb;
  localparam int NV = 10;
  // {addr[5:0], data[7:0]} write vectors; read back expected after all writes
  localparam logic [13:0] VEC [NV] = '{
    {6'd0,  8'h11}, {6'd31, 8'h22}, {6'd32, 8'h33}, {6'd63, 8'h44},
    {6'd5,  8'h5A}, {6'd37, 8'hA5}, {6'd18, 8'hFF}, {6'd50, 8'h01},
    {6'd5,  8'h6B}, {6'd0,  8'h80}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_cs_n = 1'b1;
  logic        bus_rw = 1'b1;
  logic        ext_clk = 1'b1;
  logic        ext_sync_n = 1'b1;
  logic        tb_oe = 1'b0;
  logic [7:0]  tb_d = '0;
  wire  [7:0]  bus_data;
  logic [511:0] regs_flat;
  logic [7:0]  model [64];
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  assign bus_data = tb_oe ? tb_d : 'z;

  sndbus_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rw(bus_rw), .bus_data(bus_data), .ext_clk(ext_clk),
    .ext_sync_n(ext_sync_n), .regs_flat(regs_flat)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr_fast(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; tb_d = d; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b0;
    @(negedge clk);
    bus_cs_n = 1'b1; bus_rw = 1'b1; tb_oe = 1'b0;
    model[a] = d;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rw = 1'b1; bus_cs_n = 1'b0;
    #1 d = bus_data;
    bus_cs_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got 00 expected 01");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    idle(3);
    // R1: during reset the image is zero
    chk(regs_flat == '0, "R1 image in reset", regs_flat[7:0], 8'h00);
    rst_n = 1'b1;
    idle(2);
    rd(6'd0, v);  chk(v == 8'h00, "R1 bank0 reg0", v, 8'h00);
    rd(6'd63, v); chk(v == 8'h00, "R1 bank1 reg31", v, 8'h00);

    // R2 R3 R5 R9: table of writes, then full readback
    for (int i = 0; i < NV; i++) wr_fast(VEC[i][13:8], VEC[i][7:0]);
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), v);
      chk(v == model[a], "R5 readback", v, model[a]);
    end
    for (int a = 0; a < 64; a++)
      chk(regs_flat[a*8 +: 8] == model[a], "R9 image slice", regs_flat[a*8 +: 8], model[a]);
    // R3: same index in both banks holds different values
    chk(model[5] != model[37] && regs_flat[5*8 +: 8] == 8'h6B && regs_flat[37*8 +: 8] == 8'hA5,
        "R3 bank split", regs_flat[37*8 +: 8], 8'hA5);

    // R2: held access stores only the first byte
    @(negedge clk);
    bus_addr = 6'd9; tb_d = 8'h12; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b0;
    @(negedge clk);
    tb_d = 8'h34; bus_addr = 6'd10;
    @(negedge clk);
    bus_cs_n = 1'b1; bus_rw = 1'b1; tb_oe = 1'b0;
    rd(6'd9, v);  chk(v == 8'h12, "R2 first byte kept", v, 8'h12);
    rd(6'd10, v); chk(v == 8'h00, "R2 no second commit", v, 8'h00);

    // R4: chip select high -> no write, bus not driven by block
    @(negedge clk);
    bus_addr = 6'd9; tb_d = 8'hED; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b1;
    idle(2);
    bus_rw = 1'b1;
    #1 chk(bus_data == 8'hED, "R4 bus released", bus_data, 8'hED);
    tb_oe = 1'b0;
    rd(6'd9, v); chk(v == 8'h12, "R4 no write while deselected", v, 8'h12);

    // R6: during a write the bus holds the host byte
    @(negedge clk);
    bus_addr = 6'd40; tb_d = 8'hC3; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b0;
    #1 chk(bus_data == 8'hC3, "R6 no drive in write", bus_data, 8'hC3);
    @(negedge clk);
    tb_d = 8'h3C;
    #1 chk(bus_data == 8'h3C, "R6 no drive held write", bus_data, 8'h3C);
    bus_cs_n = 1'b1; bus_rw = 1'b1; tb_oe = 1'b0;

    // R7: sync mode, no ext edge -> nothing stored
    ext_clk = 1'b0; ext_sync_n = 1'b0;
    idle(4);
    @(negedge clk);
    bus_addr = 6'd20; tb_d = 8'h77; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b0;
    idle(5);
    bus_cs_n = 1'b1; bus_rw = 1'b1; tb_oe = 1'b0;
    rd(6'd20, v); chk(v == 8'h00, "R7 no edge no write", v, 8'h00);
    // R7: access released after two edges -> too early, not stored
    @(negedge clk);
    bus_addr = 6'd20; tb_d = 8'h78; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b0;
    ext_clk = 1'b1;
    idle(2);
    bus_cs_n = 1'b1; bus_rw = 1'b1; tb_oe = 1'b0;
    idle(2);
    ext_clk = 1'b0;
    idle(4);
    rd(6'd20, v); chk(v == 8'h00, "R7 not before third edge", v, 8'h00);
    // R7: held through the third edge -> stored
    @(negedge clk);
    bus_addr = 6'd52; tb_d = 8'h79; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b0;
    ext_clk = 1'b1;
    idle(3);
    bus_cs_n = 1'b1; bus_rw = 1'b1; tb_oe = 1'b0;
    rd(6'd52, v); chk(v == 8'h79, "R7 third edge write", v, 8'h79);

    // R8: two ext edges in one access -> later byte wins
    ext_clk = 1'b0;
    idle(4);
    @(negedge clk);
    bus_addr = 6'd21; tb_d = 8'h0A; tb_oe = 1'b1; bus_rw = 1'b0; bus_cs_n = 1'b0;
    ext_clk = 1'b1;
    idle(4);
    ext_clk = 1'b0;
    idle(4);
    tb_d = 8'h0B;
    ext_clk = 1'b1;
    idle(4);
    bus_cs_n = 1'b1; bus_rw = 1'b1; tb_oe = 1'b0;
    rd(6'd21, v); chk(v == 8'h0B, "R8 per-edge commit", v, 8'h0B);
    ext_sync_n = 1'b1;

    // R1: reset again clears both banks
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
    chk(regs_flat == '0, "R1 image after reset", regs_flat[37*8 +: 8], 8'h00);
    rd(6'd52, v); chk(v == 8'h00, "R1 reg cleared", v, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule